// File: doc/BRIEF.md
# Shared Address/Data Host Bus to Wishbone Bridge

This block connects a processor's synchronous external memory port to a 16-bit Wishbone fabric. The host puts an address and then data on the same 16 lines. It also drives an active-low address-valid strobe, a read/not-write line and an active-low chip select, all timed by its own bus clock. The bridge runs entirely in that clock domain. Each host access produces exactly one Wishbone master cycle.

On a write, the bridge latches the address while the strobe is low and takes the data on the following cycle. It then runs the Wishbone write. On a read, it runs the Wishbone read straight after the address phase and registers the returned word on acknowledge. It presents that word back to the host until the access ends. The shared lines are split into an input, an output and an output enable, and the pad ring joins them into the bidirectional pins. The bridge also sends the fabric's interrupt sources to the host on one level-sensitive pin.

Top module: `mux_bus_wb_bridge`

## Requirements
- R1: While `rst` is high and in the cycle after it, `wb_cyc_o`, `wb_stb_o`, `bus_ad_oe` and `host_irq_o` are all 0.
- R2: An address phase is a rising clock edge where `bus_cs_n`=0 and `bus_adv_n`=0. The value on `bus_ad_i` at that edge appears on `wb_adr_o` for the whole Wishbone cycle it starts.
- R3: A low `bus_adv_n` while `bus_cs_n`=1 starts no Wishbone cycle.
- R4: When `bus_rnw`=0 at the address phase, the access is a write. The bridge captures `bus_ad_i` at the next rising edge and then raises `wb_cyc_o` with `wb_we_o`=1 and `wb_dat_o` equal to that word.
- R5: When `bus_rnw`=1 at the address phase, `wb_cyc_o`/`wb_stb_o` rise at that same edge with `wb_we_o`=0. For both reads and writes, cyc and stb stay high until an edge that samples `wb_ack_i`=1, and drop at that edge. Each access gives one Wishbone cycle.
- R6: On a read, `wb_dat_i` is registered at the acknowledging edge. From the second edge after the address phase, while `bus_cs_n`=0, `bus_ad_oe`=1 and `bus_ad_o` shows the registered word. After acknowledge, the word stays unchanged until the access ends.
- R7: `bus_ad_oe` falls at the first edge that samples `bus_cs_n`=1. It is never 1 during a write access or while the host is driving the lines.
- R8: `host_irq_o` equals the OR of `irq_src_i` sampled at the previous edge. It is active-high and level-sensitive.
- R9: A Wishbone cycle that has started stays asserted until acknowledge, even if `bus_cs_n` returns high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_adv_n | input | 1 | Address-valid strobe, active low |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_ad_i | input | 16 | Shared address/data lines, input side |
| bus_ad_o | output | 16 | Shared lines, read data output side |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| wb_adr_o | output | 16 | Wishbone address |
| wb_dat_o | output | 16 | Wishbone write data |
| wb_dat_i | input | 16 | Wishbone read data |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| irq_src_i | input | 4 | Fabric interrupt sources |
| host_irq_o | output | 1 | Interrupt to host, active high |

## Verification
The assertions rely on a host that does not start a new address phase while a Wishbone cycle is still open. They also rely on a fabric that returns acknowledge only while cyc and stb are high. The stimulus keeps to both rules. Every host task holds the access for longer than the slave latency it has set, except in the early-release case. After that case, the bench waits until the cycle has closed before it begins the next access. The bench's slave model raises acknowledge for exactly one cycle and only on an open cycle, so no extra or stray acknowledge reaches the bridge.

// File: rtl/mux_bus_wb_bridge.sv
module mux_bus_wb_bridge #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_cs_n,
  input  logic            bus_adv_n,
  input  logic            bus_rnw,
  input  logic [DW-1:0]   bus_ad_i,
  output logic [DW-1:0]   bus_ad_o,
  output logic            bus_ad_oe,
  output logic [AW-1:0]   wb_adr_o,
  output logic [DW-1:0]   wb_dat_o,
  input  logic [DW-1:0]   wb_dat_i,
  output logic            wb_we_o,
  output logic            wb_cyc_o,
  output logic            wb_stb_o,
  input  logic            wb_ack_i,
  input  logic [NIRQ-1:0] irq_src_i,
  output logic            host_irq_o
);

  typedef enum logic [1:0] {S_IDLE, S_WDATA, S_BUSY, S_HOLD} state_t;

  state_t          st;
  logic [AW-1:0]   adr_q;
  logic [DW-1:0]   wdat_q;
  logic [DW-1:0]   rdat_q;
  logic            rnw_q;
  logic            oe_q;
  logic            irq_q;

  wire addr_phase = !bus_cs_n && !bus_adv_n;
  wire can_start  = (st == S_IDLE) || (st == S_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      adr_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      rnw_q  <= 1'b1;
      oe_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= |irq_src_i;
      oe_q  <= !bus_cs_n && bus_adv_n && rnw_q && (st != S_IDLE);
      if (can_start && addr_phase) begin
        adr_q <= bus_ad_i[AW-1:0];
        rnw_q <= bus_rnw;
        st    <= bus_rnw ? S_BUSY : S_WDATA;
      end else begin
        case (st)
          S_WDATA: begin
            wdat_q <= bus_ad_i;
            st     <= S_BUSY;
          end
          S_BUSY: if (wb_ack_i) begin
            if (rnw_q) rdat_q <= wb_dat_i;
            st <= bus_cs_n ? S_IDLE : S_HOLD;
          end
          S_HOLD: if (bus_cs_n) st <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign wb_cyc_o   = (st == S_BUSY);
  assign wb_stb_o   = (st == S_BUSY);
  assign wb_we_o    = !rnw_q;
  assign wb_adr_o   = adr_q;
  assign wb_dat_o   = wdat_q;
  assign bus_ad_o   = rdat_q;
  assign bus_ad_oe  = oe_q;
  assign host_irq_o = irq_q;

endmodule

module mux_bus_wb_bridge_chk #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int NIRQ = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cs_n,
  input logic            adv_n,
  input logic [NIRQ-1:0] src,
  input logic            irq,
  input logic            cyc,
  input logic            we,
  input logic            ack,
  input logic [AW-1:0]   adr,
  input logic            oe,
  input logic [DW-1:0]   ado
);

  AST_HOLD_TO_ACK: assert property (@(posedge clk) disable iff (rst) cyc && !ack |=> cyc); // R9
  AST_DROP_ON_ACK: assert property (@(posedge clk) disable iff (rst) cyc && ack |=> !cyc); // R5
  AST_ADR_STABLE: assert property (@(posedge clk) disable iff (rst) cyc && !ack |=> $stable(adr)); // R2
  AST_READ_START: assert property (@(posedge clk) disable iff (rst) $rose(cyc) && !we |-> $past(!cs_n && !adv_n)); // R3
  AST_WRITE_START: assert property (@(posedge clk) disable iff (rst) $rose(cyc) && we |-> $past(!cs_n && !adv_n, 2)); // R4
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst) $past(cs_n) |-> !oe); // R7
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst) oe && !cyc && $past(oe && !cyc) |-> $stable(ado)); // R6
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> irq == $past(|src)); // R8

endmodule

bind mux_bus_wb_bridge mux_bus_wb_bridge_chk #(.AW(AW), .DW(DW), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst(rst), .cs_n(bus_cs_n), .adv_n(bus_adv_n), .src(irq_src_i),
  .irq(host_irq_o), .cyc(wb_cyc_o), .we(wb_we_o), .ack(wb_ack_i),
  .adr(wb_adr_o), .oe(bus_ad_oe), .ado(bus_ad_o)
);

// File: tb/test_mux_bus_wb_bridge.sv
module test_mux_bus_wb_bridge;
  localparam int DW = 16;
  localparam int NI = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          cs_n = 1'b1, adv_n = 1'b1, rnw = 1'b1;
  logic [DW-1:0] h_ad = '0;
  logic          h_drv = 1'b0;
  logic [NI-1:0] src = '0;
  logic          ack = 1'b0;
  logic [DW-1:0] wb_din = '0;

  logic [DW-1:0] ad_o, adr, dat_o;
  logic          oe, we, cyc, stb, irq;

  mux_bus_wb_bridge #(.AW(DW), .DW(DW), .NIRQ(NI)) i_mux_bus_wb_bridge (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_adv_n(adv_n), .bus_rnw(rnw),
    .bus_ad_i(h_ad), .bus_ad_o(ad_o), .bus_ad_oe(oe),
    .wb_adr_o(adr), .wb_dat_o(dat_o), .wb_dat_i(wb_din), .wb_we_o(we),
    .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_ack_i(ack),
    .irq_src_i(src), .host_irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Fabric slave
  logic [DW-1:0] mem [16];
  int lat = 0, wcnt = 0, acks = 0;
  always @(negedge clk) begin
    if (ack) ack <= 1'b0;
    else if (cyc && stb) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        acks++;
        if (we) mem[adr[3:0]] = dat_o;
        wb_din <= mem[adr[3:0]];
        ack <= 1'b1;
      end else wcnt++;
    end
  end

  // Reference model
  int m_ph = 0;
  logic [DW-1:0] m_adr = '0, m_wd = '0, m_rd = '0;
  logic m_rnw = 1'b1, m_oe = 1'b0, m_irq = 1'b0;
  bit model_on = 0;
  always @(posedge clk) begin
    logic n_oe;
    model_on = 1;
    if (rst) begin
      m_ph = 0; m_adr = '0; m_wd = '0; m_rd = '0; m_rnw = 1'b1; m_oe = 1'b0; m_irq = 1'b0;
    end else begin
      n_oe = !cs_n && adv_n && m_rnw && (m_ph != 0);
      m_irq = (src != 0);
      if ((m_ph == 0 || m_ph == 3) && !cs_n && !adv_n) begin
        m_adr = h_ad; m_rnw = rnw; m_ph = rnw ? 2 : 1;
      end else if (m_ph == 1) begin
        m_wd = h_ad; m_ph = 2;
      end else if (m_ph == 2) begin
        if (ack) begin
          if (m_rnw) m_rd = wb_din;
          m_ph = cs_n ? 0 : 3;
        end
      end else if (m_ph == 3 && cs_n) m_ph = 0;
      m_oe = n_oe;
    end
  end

  always @(posedge clk) begin
    #1;
    if (model_on && !finished) begin
      chk("R5 cyc", cyc, m_ph == 2);
      chk("R5 stb", stb, m_ph == 2);
      if (m_ph == 2) begin
        chk("R5 we", we, !m_rnw);
        chk("R2 adr", adr, m_adr);
        if (!m_rnw) chk("R4 wdata", dat_o, m_wd);
      end
      chk("R7 oe", oe, m_oe);
      if (m_oe) chk("R6 rdata", ad_o, m_rd);
      if (h_drv) chk("R7 no contention", oe, 0);
      chk("R8 irq", irq, m_irq);
    end
  end

  logic [DW-1:0] shadow [16];

  task automatic host_write(input logic [DW-1:0] a, input logic [DW-1:0] d, input int hold);
    @(negedge clk); cs_n = 0; adv_n = 0; rnw = 0; h_ad = a; h_drv = 1;
    @(negedge clk); adv_n = 1; h_ad = d;
    repeat (hold) @(negedge clk);
    cs_n = 1; h_drv = 0; h_ad = '0;
    shadow[a[3:0]] = d;
  endtask

  task automatic host_read(input logic [DW-1:0] a, input int hold, input bit keep);
    @(negedge clk); cs_n = 0; adv_n = 0; rnw = 1; h_ad = a; h_drv = 1;
    @(negedge clk); adv_n = 1; h_ad = '0; h_drv = 0;
    repeat (hold) @(negedge clk);
    chk("R6 oe during read", oe, 1);
    chk("R6 host read value", ad_o, shadow[a[3:0]]);
    if (!keep) cs_n = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int a0;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 16'h1000 + 16'(i * 16'h0111);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk("R1 cyc in reset", cyc, 0);
    chk("R1 oe in reset", oe, 0);
    chk("R1 irq in reset", irq, 0);
    src = 4'b0010;
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 idle after reset", {cyc, oe}, 0);

    lat = 0; host_write(16'h0003, 16'hCAFE, 3);
    lat = 2; host_write(16'h0005, 16'h5A5A, 5);
    @(negedge clk); src = 4'b0000;
    lat = 0; host_read(16'h0003, 3, 0);
    lat = 3; host_read(16'h0005, 6, 0);
    lat = 1; host_read(16'h0009, 4, 1);
    host_read(16'h0003, 4, 0);
    src = 4'b1000;
    @(negedge clk); @(negedge clk);
    chk("R8 irq level", irq, 1);
    src = 4'b0000;

    a0 = acks;
    @(negedge clk); adv_n = 0; rnw = 1; h_ad = 16'h0004; h_drv = 1;
    @(negedge clk); adv_n = 1; h_drv = 0;
    repeat (4) @(negedge clk);
    chk("R3 ignored strobe", acks, a0);
    chk("R3 no cycle", cyc, 0);

    lat = 6;
    @(negedge clk); cs_n = 0; adv_n = 0; rnw = 1; h_ad = 16'h0007; h_drv = 1;
    @(negedge clk); adv_n = 1; h_ad = '0; h_drv = 0;
    @(negedge clk); cs_n = 1;
    @(negedge clk);
    chk("R9 cyc held after cs high", cyc, 1);
    chk("R7 released after cs high", oe, 0);
    repeat (10) @(negedge clk);
    chk("R9 cycle closed", cyc, 0);
    chk("R5 one ack for access", acks, a0 + 1);

    lat = 0; host_write(16'h000C, 16'h0F0F, 3);
    host_read(16'h000C, 3, 0);
    chk("R4 slave stored write", mem[12], 16'h0F0F);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule